// File: doc/BRIEF.md
# Background Tile Pixel Fetch Pipeline

This block turns a pixel coordinate on the background layer into that pixel's 3-bit colour index and 3-bit palette index. The layer is a grid of 16x16-pixel tiles, 40 tiles across. For each request the block first reads the attribute word of the tile that covers the coordinate. That word carries the tile's pattern number, its palette and its two mirror flags. The block applies the mirroring to the pixel's position inside the tile. It then reads the one pattern word that holds the pixel and picks out the pixel's 3-bit field.

Pattern data is packed five 3-bit pixels to a word, 52 words per tile. The word number is therefore the in-tile pixel index divided by 5, and the field is the index modulo 5. A small multiply-by-reciprocal circuit computes both, with no general divider.

The block is a fixed-latency pipeline. It takes one request per cycle over a valid/ready handshake. It drives two synchronous read ports, one for attributes and one for patterns; each returns data a fixed number of cycles after the address. Results come out in request order with a single valid strobe.

Top module: `bg_tile_pixel_fetch`

## Requirements
- R1: `reqReady` is 0 while `rst` is 1 and 1 from the second clock edge after reset is released. From then on a request is accepted on every cycle where `reqValid` is 1.
- R2: In the cycle after an accepted request, `attrRdEn` is 1 and `attrRdAddr` equals ATTR_BASE + floor(x/16) + floor(y/16)*40. `attrRdEn` is 0 in every other cycle.
- R3: The attribute word is decoded as follows: bit 14 mirrors the tile left-right, bit 13 mirrors it top-bottom, bits 12..10 are the palette and bits 9..0 are the pattern number. Bit 15 has no effect on any output.
- R4: Take col = x mod 16 and row = y mod 16. A left-right mirror replaces col with 15-col and a top-bottom mirror replaces row with 15-row. The in-tile index p = row*16 + col is formed after the mirroring.
- R5: ATTR_LAT+1 cycles after `attrRdEn`, `patRdEn` is 1 and `patRdAddr` equals PAT_BASE + 52*pattern + floor(p/5), taken modulo 2^16. `patRdEn` is 0 in every other cycle.
- R6: `resultColor` is bits [3f+2:3f] of the pattern word, where f = p mod 5. Bit 15 of the word has no effect. For p = 255, word 51 of the tile is read and its bits 2..0 are used.
- R7: `resultPalette` equals bits 12..10 of the attribute word read for the same request.
- R8: `resultValid` is 1 exactly ATTR_LAT+PAT_LAT+3 cycles after each accepted request and at no other time, so results leave in request order.
- R9: In the cycle after any cycle with `rst` high, `attrRdEn`, `patRdEn` and `resultValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|-|-|-|-|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqX | input | COORD_W | Pixel column on the background layer |
| reqY | input | COORD_W | Pixel row on the background layer |
| attrRdEn | output | 1 | Attribute read strobe |
| attrRdAddr | output | ADDR_W | Attribute word address |
| attrRdData | input | DATA_W | Attribute word, ATTR_LAT cycles after the address |
| patRdEn | output | 1 | Pattern read strobe |
| patRdAddr | output | ADDR_W | Pattern word address |
| patRdData | input | DATA_W | Pattern word, PAT_LAT cycles after the address |
| resultValid | output | 1 | Result strobe |
| resultColor | output | 3 | Colour index of the pixel |
| resultPalette | output | 3 | Palette index of the tile |

## Verification
The bench goes after the corners of the divide-by-5 packing: p = 255, which lands alone in word 51; the word edges at p = 4 and 5; and field 4, which sits just under the ignored bit 15. A slightly wrong reciprocal or remainder would read the next word or the wrong field at exactly those points. Tiles are hit with each mirror flag alone and with both, since swapped flag bits or a mirror applied after forming p would turn p = 0 into a pixel other than 255. The bench runs with an attribute latency different from the pattern latency and with back-to-back requests. A delay line of the wrong length or misaligned then pairs one request's palette with another request's pixel. The last tile of the grid and pattern number 1023 test the address sums at their widest.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

  localparam int TileSideBits = 4;
  localparam int PixIdxW      = 2 * TileSideBits;
  localparam int FieldW       = 3;
  localparam int FieldsPerWord = 5;
  localparam int WordIdxW     = 6;
  localparam int SelW         = 3;

  typedef struct packed {
    logic       reqLoad;
    logic       attrLoad;
    logic       patLoad;
  } fetchStrobes_t;

  typedef struct packed {
    logic       mirrorX;
    logic       mirrorY;
    logic [2:0] palette;
    logic [9:0] pattern;
  } tileAttr_t;

  // floor(p/5) for p in 0..255: p*205 >> 10 is exact on that range.
  function automatic logic [WordIdxW-1:0] divBy5(input logic [PixIdxW-1:0] p);
    logic [15:0] acc;
    acc = {1'b0, p, 7'b0} + {2'b0, p, 6'b0} + {5'b0, p, 3'b0} +
          {6'b0, p, 2'b0} + {8'b0, p};
    return acc[15:10];
  endfunction

endpackage

// File: rtl/bgf_delay.sv
module bgf_delay #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/bgf_ctrl.sv
module bgf_ctrl
  import bgf_pkg::*;
#(
  parameter int ATTR_LAT = 1,
  parameter int PAT_LAT  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  output logic          reqReady,
  output fetchStrobes_t strobes,
  output logic          attrRdEn,
  output logic          patRdEn,
  output logic          resultValid
);

  localparam int Depth = ATTR_LAT + PAT_LAT + 3;
  localparam int CntW  = $clog2(Depth + 1) + 1;

  logic readyQ;
  logic accept;
  logic attrIssueQ;
  logic attrBack;
  logic patIssueQ;
  logic patBack;
  logic outQ;
  logic [CntW-1:0] inFlight;

  assign accept = reqValid && readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ     <= 1'b0;
      attrIssueQ <= 1'b0;
      patIssueQ  <= 1'b0;
      outQ       <= 1'b0;
    end else begin
      readyQ     <= 1'b1;
      attrIssueQ <= accept;
      patIssueQ  <= attrBack;
      outQ       <= patBack;
    end
  end

  bgf_delay #(.WIDTH(1), .STAGES(ATTR_LAT)) u_attrWait (
    .clk(clk), .rst(rst), .din(attrIssueQ), .dout(attrBack)
  );

  bgf_delay #(.WIDTH(1), .STAGES(PAT_LAT)) u_patWait (
    .clk(clk), .rst(rst), .din(patIssueQ), .dout(patBack)
  );

  assign reqReady         = readyQ;
  assign attrRdEn         = attrIssueQ;
  assign patRdEn          = patIssueQ;
  assign resultValid      = outQ;
  assign strobes.reqLoad  = accept;
  assign strobes.attrLoad = attrBack;
  assign strobes.patLoad  = patBack;

  // Requests in flight, kept to check result accounting.
  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + CntW'(accept) - CntW'(outQ);
  end

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> reqReady);

  p_attr_rd_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> attrRdEn);

  p_no_orphan_result_r8: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> (inFlight != '0));

  p_inflight_bound_r8: assert property (@(posedge clk) disable iff (rst)
    inFlight <= CntW'(Depth));

  p_idle_after_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!attrRdEn && !patRdEn && !resultValid));

endmodule

// File: rtl/bgf_datapath.sv
module bgf_datapath
  import bgf_pkg::*;
#(
  parameter int          COORD_W        = 10,
  parameter int          ADDR_W         = 16,
  parameter int          DATA_W         = 16,
  parameter int          MAP_TILES_W    = 40,
  parameter int          WORDS_PER_TILE = 52,
  parameter logic [15:0] ATTR_BASE      = 16'hD000,
  parameter logic [15:0] PAT_BASE       = 16'h0000,
  parameter int          ATTR_LAT       = 1,
  parameter int          PAT_LAT        = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  fetchStrobes_t      strobes,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  output logic [ADDR_W-1:0]  attrRdAddr,
  input  logic [DATA_W-1:0]  attrRdData,
  output logic [ADDR_W-1:0]  patRdAddr,
  input  logic [DATA_W-1:0]  patRdData,
  output logic [FieldW-1:0]  resultColor,
  output logic [2:0]         resultPalette
);

  localparam int TileCoordW = COORD_W - TileSideBits;
  localparam int TagW       = 3 + SelW;

  // Stage 1: attribute address and in-tile position.
  logic [TileCoordW-1:0]   tileX;
  logic [TileCoordW-1:0]   tileY;
  logic [ADDR_W-1:0]       attrAddrNext;
  logic [ADDR_W-1:0]       attrAddrQ;
  logic [PixIdxW-1:0]      posQ;
  logic [PixIdxW-1:0]      posAtAttr;

  assign tileX = reqX[COORD_W-1:TileSideBits];
  assign tileY = reqY[COORD_W-1:TileSideBits];
  assign attrAddrNext = ADDR_W'(ATTR_BASE) + ADDR_W'(tileX) +
                        ADDR_W'(tileY) * ADDR_W'(MAP_TILES_W);

  always_ff @(posedge clk) begin
    if (strobes.reqLoad) begin
      attrAddrQ <= attrAddrNext;
      posQ      <= {reqY[TileSideBits-1:0], reqX[TileSideBits-1:0]};
    end
  end

  assign attrRdAddr = attrAddrQ;

  bgf_delay #(.WIDTH(PixIdxW), .STAGES(ATTR_LAT)) u_posAlign (
    .clk(clk), .rst(rst), .din(posQ), .dout(posAtAttr)
  );

  // Stage 2: decode attributes, mirror, split index into word and field.
  tileAttr_t               attrWord;
  logic [TileSideBits-1:0] colM;
  logic [TileSideBits-1:0] rowM;
  logic [PixIdxW-1:0]      pixIdx;
  logic [WordIdxW-1:0]     wordInTile;
  logic [PixIdxW-1:0]      wordBase;
  logic [PixIdxW-1:0]      remainder;
  logic [SelW-1:0]         fieldSel;
  logic [ADDR_W-1:0]       patAddrNext;
  logic [ADDR_W-1:0]       patAddrQ;
  logic [TagW-1:0]         tagQ;
  logic [TagW-1:0]         tagAtPat;

  assign attrWord   = tileAttr_t'(attrRdData[14:0]);
  assign colM       = posAtAttr[TileSideBits-1:0] ^ {TileSideBits{attrWord.mirrorX}};
  assign rowM       = posAtAttr[PixIdxW-1:TileSideBits] ^ {TileSideBits{attrWord.mirrorY}};
  assign pixIdx     = {rowM, colM};
  assign wordInTile = divBy5(pixIdx);
  assign wordBase   = {wordInTile, 2'b00} + {2'b00, wordInTile};
  assign remainder  = pixIdx - wordBase;
  assign fieldSel   = remainder[SelW-1:0];
  assign patAddrNext = ADDR_W'(PAT_BASE) +
                       ADDR_W'(attrWord.pattern) * ADDR_W'(WORDS_PER_TILE) +
                       ADDR_W'(wordInTile);

  always_ff @(posedge clk) begin
    if (strobes.attrLoad) begin
      patAddrQ <= patAddrNext;
      tagQ     <= {attrWord.palette, fieldSel};
    end
  end

  assign patRdAddr = patAddrQ;

  p_field_sel_range_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.attrLoad |-> (remainder < PixIdxW'(FieldsPerWord)));

  p_last_word_single_r6: assert property (@(posedge clk) disable iff (rst)
    (strobes.attrLoad && wordInTile == WordIdxW'(WORDS_PER_TILE - 1)) |-> (fieldSel == '0));

  bgf_delay #(.WIDTH(TagW), .STAGES(PAT_LAT)) u_tagAlign (
    .clk(clk), .rst(rst), .din(tagQ), .dout(tagAtPat)
  );

  // Stage 3: field select from the pattern word.
  logic [FieldW-1:0] fieldArr [FieldsPerWord];
  logic [FieldW-1:0] pickedField;
  logic [SelW-1:0]   selAtPat;
  logic [FieldW-1:0] colorQ;
  logic [2:0]        paletteQ;

  assign selAtPat = tagAtPat[SelW-1:0];

  for (genvar f = 0; f < FieldsPerWord; f++) begin : g_field
    assign fieldArr[f] = patRdData[FieldW*f +: FieldW];
  end

  always_comb begin
    pickedField = '0;
    for (int k = 0; k < FieldsPerWord; k++) begin
      if (selAtPat == SelW'(k)) pickedField = fieldArr[k];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.patLoad) begin
      colorQ   <= pickedField;
      paletteQ <= tagAtPat[TagW-1:SelW];
    end
  end

  assign resultColor   = colorQ;
  assign resultPalette = paletteQ;

endmodule

// File: rtl/bg_tile_pixel_fetch.sv
module bg_tile_pixel_fetch
  import bgf_pkg::*;
#(
  parameter int          COORD_W        = 10,
  parameter int          ADDR_W         = 16,
  parameter int          DATA_W         = 16,
  parameter int          MAP_TILES_W    = 40,
  parameter int          WORDS_PER_TILE = 52,
  parameter logic [15:0] ATTR_BASE      = 16'hD000,
  parameter logic [15:0] PAT_BASE       = 16'h0000,
  parameter int          ATTR_LAT       = 1,
  parameter int          PAT_LAT        = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  output logic               attrRdEn,
  output logic [ADDR_W-1:0]  attrRdAddr,
  input  logic [DATA_W-1:0]  attrRdData,
  output logic               patRdEn,
  output logic [ADDR_W-1:0]  patRdAddr,
  input  logic [DATA_W-1:0]  patRdData,
  output logic               resultValid,
  output logic [2:0]         resultColor,
  output logic [2:0]         resultPalette
);

  fetchStrobes_t strobes;

  bgf_ctrl #(.ATTR_LAT(ATTR_LAT), .PAT_LAT(PAT_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .strobes(strobes), .attrRdEn(attrRdEn), .patRdEn(patRdEn),
    .resultValid(resultValid)
  );

  bgf_datapath #(
    .COORD_W(COORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MAP_TILES_W(MAP_TILES_W), .WORDS_PER_TILE(WORDS_PER_TILE),
    .ATTR_BASE(ATTR_BASE), .PAT_BASE(PAT_BASE),
    .ATTR_LAT(ATTR_LAT), .PAT_LAT(PAT_LAT)
  ) u_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .reqX(reqX), .reqY(reqY),
    .attrRdAddr(attrRdAddr), .attrRdData(attrRdData),
    .patRdAddr(patRdAddr), .patRdData(patRdData),
    .resultColor(resultColor), .resultPalette(resultPalette)
  );

endmodule

// File: tb/tb_bg_tile_pixel_fetch.sv
`timescale 1ns/1ps
module tb_bg_tile_pixel_fetch;

  localparam int          AL       = 2;
  localparam int          PL       = 1;
  localparam logic [15:0] ABASE    = 16'hD000;
  localparam logic [15:0] PBASE    = 16'h0000;
  localparam int          ATTR_CNT = 1200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [9:0]  reqX = '0;
  logic [9:0]  reqY = '0;
  logic        attrRdEn;
  logic [15:0] attrRdAddr;
  logic [15:0] attrRdData;
  logic        patRdEn;
  logic [15:0] patRdAddr;
  logic [15:0] patRdData;
  logic        resultValid;
  logic [2:0]  resultColor;
  logic [2:0]  resultPalette;

  always #5 clk = ~clk;

  bg_tile_pixel_fetch #(.ATTR_BASE(ABASE), .PAT_BASE(PBASE),
                        .ATTR_LAT(AL), .PAT_LAT(PL)) dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqX(reqX), .reqY(reqY),
    .attrRdEn(attrRdEn), .attrRdAddr(attrRdAddr), .attrRdData(attrRdData),
    .patRdEn(patRdEn), .patRdAddr(patRdAddr), .patRdData(patRdData),
    .resultValid(resultValid), .resultColor(resultColor),
    .resultPalette(resultPalette)
  );

  // Memory models
  logic [15:0] attrMem [ATTR_CNT];

  function automatic logic [15:0] patWord(input logic [15:0] a);
    logic [15:0] m;
    m = a * 16'hA3C5;
    return m ^ {a[7:0], a[15:8]};
  endfunction

  function automatic logic [15:0] attrLookup(input logic [15:0] a);
    int idx;
    idx = int'(a) - int'(ABASE);
    if (idx >= 0 && idx < ATTR_CNT) return attrMem[idx];
    return 16'h0000;
  endfunction

  logic [15:0] attrPipe [AL];
  logic [15:0] patPipe  [PL];

  always @(posedge clk) begin
    attrPipe[0] <= attrRdEn ? attrLookup(attrRdAddr) : 16'hDEAD;
    for (int i = 1; i < AL; i++) attrPipe[i] <= attrPipe[i-1];
    patPipe[0] <= patRdEn ? patWord(patRdAddr) : 16'hBEEF;
    for (int i = 1; i < PL; i++) patPipe[i] <= patPipe[i-1];
  end
  assign attrRdData = attrPipe[AL-1];
  assign patRdData  = patPipe[PL-1];

  // Scoreboard
  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  logic        attrExpV [64];
  logic [15:0] attrExpA [64];
  logic        patExpV  [64];
  logic [15:0] patExpA  [64];
  logic [2:0]  expColor [4096];
  logic [2:0]  expPal   [4096];
  int          expCyc   [4096];
  int wrPtr = 0;
  int rdPtr = 0;

  function automatic int pixIndex(input logic [9:0] x, input logic [9:0] y,
                                  input logic [15:0] attr);
    int col;
    int row;
    col = int'(x) % 16;
    row = int'(y) % 16;
    if (attr[14]) col = 15 - col;
    if (attr[13]) row = 15 - row;
    return row * 16 + col;
  endfunction

  task automatic record(input logic [9:0] x, input logic [9:0] y);
    logic [15:0] aAddr;
    logic [15:0] attr;
    logic [15:0] pAddr;
    logic [15:0] w;
    int p;
    aAddr = ABASE + 16'(int'(x) / 16) + 16'((int'(y) / 16) * 40);
    attr  = attrLookup(aAddr);
    p     = pixIndex(x, y, attr);
    pAddr = PBASE + 16'(52 * int'(attr[9:0]) + p / 5);
    w     = patWord(pAddr);
    attrExpV[(cyc + 1) % 64] = 1'b1;
    attrExpA[(cyc + 1) % 64] = aAddr;
    patExpV[(cyc + 2 + AL) % 64] = 1'b1;
    patExpA[(cyc + 2 + AL) % 64] = pAddr;
    expColor[wrPtr % 4096] = 3'((w >> (3 * (p % 5))) & 16'h7);
    expPal[wrPtr % 4096]   = attr[12:10];
    expCyc[wrPtr % 4096]   = cyc + 3 + AL + PL;
    wrPtr++;
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic checkOutputs();
    int s;
    s = cyc % 64;
    if (attrExpV[s]) begin
      check(attrRdEn === 1'b1, "R2 attrRdEn after accept", int'(attrRdEn), 1);
      check(attrRdAddr === attrExpA[s], "R2 attribute address", int'(attrRdAddr), int'(attrExpA[s]));
      attrExpV[s] = 1'b0;
    end else if (attrRdEn !== 1'b0) begin
      check(1'b0, "R2 stray attrRdEn", int'(attrRdEn), 0);
    end
    if (patExpV[s]) begin
      check(patRdEn === 1'b1, "R5 patRdEn timing", int'(patRdEn), 1);
      check(patRdAddr === patExpA[s], "R5 pattern address", int'(patRdAddr), int'(patExpA[s]));
      patExpV[s] = 1'b0;
    end else if (patRdEn !== 1'b0) begin
      check(1'b0, "R5 stray patRdEn", int'(patRdEn), 0);
    end
    if (resultValid === 1'b1) begin
      if (rdPtr == wrPtr) begin
        check(1'b0, "R8 result without request", 1, 0);
      end else begin
        check(resultColor === expColor[rdPtr % 4096], "R6 R4 colour index",
              int'(resultColor), int'(expColor[rdPtr % 4096]));
        check(resultPalette === expPal[rdPtr % 4096], "R3 R7 palette index",
              int'(resultPalette), int'(expPal[rdPtr % 4096]));
        check(cyc == expCyc[rdPtr % 4096], "R8 result cycle", cyc, expCyc[rdPtr % 4096]);
        rdPtr++;
      end
    end else if (rdPtr != wrPtr && expCyc[rdPtr % 4096] <= cyc) begin
      check(1'b0, "R8 missing result", 0, 1);
      rdPtr++;
    end
  endtask

  task automatic step(input bit v, input logic [9:0] x, input logic [9:0] y);
    @(negedge clk);
    cyc++;
    checkOutputs();
    reqValid = v;
    reqX = x;
    reqY = y;
    if (v && reqReady === 1'b1) record(x, y);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin
      attrExpV[i] = 1'b0;
      patExpV[i]  = 1'b0;
    end
    for (int i = 0; i < ATTR_CNT; i++) attrMem[i] = 16'($urandom);
    // Directed tiles: (0,0) pattern 1023 pal 5 no mirror, bit 15 set
    attrMem[0]    = {1'b1, 1'b0, 1'b0, 3'd5, 10'd1023};
    attrMem[1]    = {1'b0, 1'b1, 1'b1, 3'd2, 10'd7};
    attrMem[2]    = {1'b1, 1'b1, 1'b0, 3'd6, 10'd300};
    attrMem[3]    = {1'b0, 1'b0, 1'b1, 3'd1, 10'd12};
    attrMem[1199] = {1'b1, 1'b0, 1'b0, 3'd7, 10'd1000};

    // Reset: R1, R9
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, '0, '0);
      check(reqReady === 1'b0, "R1 ready low in reset", int'(reqReady), 0);
      check(resultValid === 1'b0 && attrRdEn === 1'b0 && patRdEn === 1'b0,
            "R9 outputs idle in reset", int'(resultValid), 0);
    end
    rst = 1'b0;
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    check(reqReady === 1'b1, "R1 ready after reset", int'(reqReady), 1);

    // Directed corners, back to back
    step(1'b1, 10'd15, 10'd15);    // p=255, word 51 field 0, pattern 1023
    step(1'b1, 10'd0, 10'd0);      // p=0
    step(1'b1, 10'd4, 10'd0);      // p=4, field 4
    step(1'b1, 10'd5, 10'd0);      // p=5, next word
    step(1'b1, 10'd16, 10'd0);     // both mirrors: p=255
    step(1'b1, 10'd20, 10'd3);     // both mirrors: p=203
    step(1'b1, 10'd37, 10'd1);     // left-right mirror only
    step(1'b1, 10'd52, 10'd0);     // top-bottom mirror only
    step(1'b1, 10'd639, 10'd479);  // last tile of the grid
    idle(AL + PL + 6);

    // R3: clear bit 15 of tile (0,0) and repeat; result must be unchanged
    attrMem[0][15] = 1'b0;
    step(1'b1, 10'd15, 10'd15);
    step(1'b1, 10'd9, 10'd13);
    idle(AL + PL + 6);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, 10'($urandom % 640), 10'($urandom % 480));
    end
    idle(AL + PL + 8);
    check(rdPtr == wrPtr, "R8 all results delivered", rdPtr, wrPtr);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule